// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This controller sits on the host side of an asynchronous byte-wide EEPROM bus and carries out one page write for each request. A request gives a start address, a byte count and a completion mode. The controller then takes exactly that many bytes from a valid/ready byte stream and keeps them in a small local buffer. After that it issues one write-enable-controlled load cycle per byte, with no gaps. Because the loads run back to back at a fixed cadence, the interval between loads stays well inside the device's load window, however slowly the stream delivered the bytes.

After the last load, the controller waits a short settle time and then checks for completion in one of two ways. In polling mode it repeatedly reads the last loaded address with the data bus released. The write is complete once bit 7 reads back as the true value of the last byte. In ready/busy mode it watches the open-drain ready line until that line reads high. If neither condition appears within a parameterised limit, the controller reports a timeout. A request whose bytes would run past the end of a page, or whose count is zero, is rejected at once with no bus activity.

Both stream interfaces follow the usual valid/ready rules. The producer holds valid and its payload steady until it sees ready in the same cycle, and a transfer happens on every clock edge where both are high. `req_ready` is high only while the controller is idle. `wd_ready` is high only while bytes are being collected, so producers simply stall at all other times. Every bus time is a parameter counted in clock cycles.

Top module: `eeprom_page_writer`

## Requirements
- R1: `req_ready` is high only while idle. After a request is accepted, `wd_ready` is high until exactly the requested number of bytes has been taken, and it is low at all other times.
- R2: A request with a count of zero, or with (address bits [4:0] + count) > 32, produces a one-cycle `error_o` pulse in the cycle after acceptance. It starts no bus cycle and takes no bytes.
- R3: Byte i of a request is loaded at the address whose bits [12:5] equal those of the start address and whose bits [4:0] equal (start offset + i). Bytes are loaded in arrival order, one load per byte.
- R4: During a load, write enable is low for exactly CYC_WP cycles. Output enable is high, chip enable is low and the data bus is driven whenever write enable is low. Address and data do not change while write enable is low.
- R5: Address and data are driven for at least CYC_SETUP cycles before write enable falls and are held for at least CYC_HOLD cycles after it rises. Successive write-enable falls within one request are exactly CYC_SETUP+CYC_WP+CYC_HOLD cycles apart.
- R6: In polling mode (`req_poll`=1), `done_o` pulses once a read of the last loaded address returns bit 7 equal to bit 7 of the last byte. It never pulses while the device still returns the inverted bit.
- R7: Output enable is never low while the controller drives the data bus.
- R8: In ready/busy mode (`req_poll`=0), `done_o` pulses after `mem_rdy_i` is seen high following the last load. It never pulses while the line is low.
- R9: If completion is not seen, `timeout_o` pulses no earlier than CYC_TIMEOUT cycles after the final write-enable rise, and `done_o` does not pulse.
- R10: Each accepted request ends with exactly one pulse on one of `done_o`, `timeout_o` or `error_o`. No further pulse follows.
- R11: After reset, chip enable, output enable and write enable are high, the data bus is released, `req_ready` is high, `wd_ready` is low and all result pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Start address of the page write |
| req_len | input | LEN_W | Byte count, 1 to PAGE_BYTES |
| req_poll | input | 1 | 1 = completion by bit-7 polling, 0 = by ready/busy line |
| wd_valid | input | 1 | Write byte valid |
| wd_ready | output | 1 | Write byte accepted when high with wd_valid |
| wd_data | input | 8 | Write byte |
| mem_addr | output | ADDR_W | Memory bus address |
| mem_dq_o | output | 8 | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_d7_i | input | 1 | Bit 7 of the memory data bus as read |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rdy_i | input | 1 | Ready/busy line, low while busy, pulled high otherwise |
| done_o | output | 1 | One-cycle pulse: write completed |
| timeout_o | output | 1 | One-cycle pulse: completion not seen in time |
| error_o | output | 1 | One-cycle pulse: request rejected |

## Verification
The bench drives requests against a behavioural device model. The model returns the inverted bit 7 while busy and holds its ready line low during the same interval. Stimulus includes a full 32-byte page from offset 0, single bytes at the last offset with bit 7 forced to 0 and to 1, random pages, offsets and lengths in both completion modes, and byte streams with random gaps. Together these separate an addressing or ordering fault from a pacing fault. Busy periods are varied, from short, to longer than the timeout, to effectively endless. Comparing when each result pulse arrives against the model's busy window distinguishes an early done, a polarity fault on bit 7 and a miscounted timeout. Zero-length requests and requests that end one byte past a page boundary probe the rejection rule.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FILL,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_SETTLE,
    ST_PREAD,
    ST_PGAP,
    ST_RBWAIT
  } pgw_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgw_buffer.sv
module pgw_buffer #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] ent_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (wr_en) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= value;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int CYC_SETUP   = 2,
  parameter int CYC_WP      = 11,
  parameter int CYC_HOLD    = 3,
  parameter int CYC_SETTLE  = 4,
  parameter int CYC_OE      = 6,
  parameter int CYC_GAP     = 2,
  parameter int CYC_TIMEOUT = 500000,
  localparam int OFF_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W      = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_poll,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [7:0]        wd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dq_o,
  output logic              mem_dq_oe,
  input  logic              mem_d7_i,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic              mem_rdy_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic              error_o
);

  localparam int PH_MAX = max_of(max_of(max_of(CYC_SETUP, CYC_WP), max_of(CYC_HOLD, CYC_SETTLE)),
                                 max_of(CYC_OE, CYC_GAP));
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int TO_W   = $clog2(CYC_TIMEOUT + 1);

  pgw_state_e        state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              poll_q;
  logic [OFF_W-1:0]  idx_q;
  logic              bit7_q;

  logic              ph_load, ph_zero, to_load, to_zero;
  logic [PH_W-1:0]   ph_val;
  logic              acc_req, take_byte, idx_clr, idx_inc, cap_bit7;
  logic              fin_done, fin_to, fin_err;
  logic [7:0]        buf_rd;
  logic [LEN_W:0]    span;
  logic              req_bad, at_last;

  // Page-crossing and empty-request check on the raw request fields
  assign span    = (LEN_W+1)'(req_addr[OFF_W-1:0]) + (LEN_W+1)'(req_len);
  assign req_bad = (req_len == '0) || (span > (LEN_W+1)'(PAGE_BYTES));
  assign at_last = (LEN_W'(idx_q) == len_q - 1'b1);

  pgw_buffer #(.DEPTH(PAGE_BYTES), .IDX_W(OFF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (take_byte),
    .wr_idx  (idx_q),
    .wr_data (wd_data),
    .rd_idx  (idx_q),
    .rd_data (buf_rd)
  );

  pgw_timer #(.W(PH_W)) u_phase (
    .clk (clk), .rst_n (rst_n), .load (ph_load), .value (ph_val), .zero (ph_zero)
  );

  pgw_timer #(.W(TO_W)) u_limit (
    .clk (clk), .rst_n (rst_n), .load (to_load),
    .value (TO_W'(CYC_TIMEOUT - 1)), .zero (to_zero)
  );

  always_comb begin
    state_d   = state_q;
    ph_load   = 1'b0;
    ph_val    = '0;
    to_load   = 1'b0;
    acc_req   = 1'b0;
    take_byte = 1'b0;
    idx_clr   = 1'b0;
    idx_inc   = 1'b0;
    cap_bit7  = 1'b0;
    fin_done  = 1'b0;
    fin_to    = 1'b0;
    fin_err   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_bad) fin_err = 1'b1;
        else begin
          acc_req = 1'b1;
          idx_clr = 1'b1;
          state_d = ST_FILL;
        end
      end
      ST_FILL: if (wd_valid) begin
        take_byte = 1'b1;
        if (at_last) begin
          idx_clr = 1'b1;
          ph_load = 1'b1;
          ph_val  = PH_W'(CYC_SETUP - 1);
          state_d = ST_SETUP;
        end else idx_inc = 1'b1;
      end
      ST_SETUP: if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = PH_W'(CYC_WP - 1);
        state_d = ST_STROBE;
      end
      ST_STROBE: if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = PH_W'(CYC_HOLD - 1);
        state_d = ST_HOLD;
      end
      ST_HOLD: if (ph_zero) begin
        ph_load = 1'b1;
        if (at_last) begin
          cap_bit7 = 1'b1;
          to_load  = 1'b1;
          ph_val   = PH_W'(CYC_SETTLE - 1);
          state_d  = ST_SETTLE;
        end else begin
          idx_inc = 1'b1;
          ph_val  = PH_W'(CYC_SETUP - 1);
          state_d = ST_SETUP;
        end
      end
      ST_SETTLE: if (ph_zero) begin
        if (poll_q) begin
          ph_load = 1'b1;
          ph_val  = PH_W'(CYC_OE - 1);
          state_d = ST_PREAD;
        end else state_d = ST_RBWAIT;
      end
      ST_PREAD: if (ph_zero) begin
        if (mem_d7_i == bit7_q) fin_done = 1'b1;
        else if (to_zero)       fin_to   = 1'b1;
        else begin
          ph_load = 1'b1;
          ph_val  = PH_W'(CYC_GAP - 1);
          state_d = ST_PGAP;
        end
      end
      ST_PGAP: if (to_zero) fin_to = 1'b1;
      else if (ph_zero) begin
        ph_load = 1'b1;
        ph_val  = PH_W'(CYC_OE - 1);
        state_d = ST_PREAD;
      end
      ST_RBWAIT: if (mem_rdy_i) fin_done = 1'b1;
      else if (to_zero)         fin_to   = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (fin_done || fin_to) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      len_q     <= '0;
      poll_q    <= 1'b0;
      idx_q     <= '0;
      bit7_q    <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (acc_req) begin
        base_q <= req_addr;
        len_q  <= req_len;
        poll_q <= req_poll;
      end
      if (idx_clr)       idx_q <= '0;
      else if (idx_inc)  idx_q <= idx_q + 1'b1;
      if (cap_bit7) bit7_q <= buf_rd[7];
      // Strobes are registered from the next state so they never glitch
      mem_ce_n  <= !(state_d inside {ST_SETUP, ST_STROBE, ST_HOLD, ST_PREAD});
      mem_oe_n  <= (state_d != ST_PREAD);
      mem_we_n  <= (state_d != ST_STROBE);
      mem_dq_oe <= (state_d inside {ST_SETUP, ST_STROBE, ST_HOLD});
      done_o    <= fin_done;
      timeout_o <= fin_to;
      error_o   <= fin_err;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign wd_ready  = (state_q == ST_FILL);
  assign mem_addr  = {base_q[ADDR_W-1:OFF_W], base_q[OFF_W-1:0] + idx_q};
  assign mem_dq_o  = buf_rd;

  // Length of the current write-enable low run, for the pulse-width check
  logic [PH_W:0] we_lo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_lo_q <= '0;
    else if (!mem_we_n) we_lo_q <= we_lo_q + 1'b1;
    else                we_lo_q <= '0;
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n); // R4
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_q == (PH_W+1)'(CYC_WP))); // R4
  AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R7
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, error_o})); // R10
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (mem_ce_n && mem_we_n && !mem_dq_oe)); // R2

endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;

  localparam int CS = 2, WP = 11, HD = 3, ST = 4, OE = 6, GP = 2, TO = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_ready, req_poll = 0;
  logic [12:0] req_addr = '0;
  logic [5:0]  req_len = '0;
  logic        wd_valid = 0, wd_ready;
  logic [7:0]  wd_data = '0;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
  logic        d7_in = 1'b1, rdy_in = 1'b1;
  logic        done_o, timeout_o, error_o;

  eeprom_page_writer #(
    .CYC_SETUP(CS), .CYC_WP(WP), .CYC_HOLD(HD), .CYC_SETTLE(ST),
    .CYC_OE(OE), .CYC_GAP(GP), .CYC_TIMEOUT(TO)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_poll(req_poll),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_d7_i(d7_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_rdy_i(rdy_in),
    .done_o(done_o), .timeout_o(timeout_o), .error_o(error_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [7:0]  mem_arr [0:8191];
  logic [12:0] ld_addr [0:63];
  logic [7:0]  ld_data [0:63];
  logic [7:0]  last_byte = '0;
  int     busy_len = 100, busy_cnt = 0, nloads = 0;
  int     tim_err = 0, intv_err = 0, cont_err = 0;
  int     we_run = 0, su_run = 0, hd_run = 0;
  bit     hd_pend = 0;
  longint cyc = 0, last_rise = 0, busy_end = 0, fall_prev = -1;
  logic        p_we = 1'b1;
  logic [12:0] p_addr = '0;
  logic [7:0]  p_dq = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) busy_end = cyc;
      end
      if (!mem_oe_n && mem_dq_oe) cont_err++;
      if (!mem_we_n) begin
        if (!mem_oe_n || mem_ce_n || !mem_dq_oe) tim_err++;
        if (!p_we) begin
          if (mem_addr != p_addr || mem_dq_o != p_dq) tim_err++;
        end else begin
          if (su_run < CS) tim_err++;
          if (fall_prev >= 0 && (cyc - fall_prev) != CS + WP + HD) intv_err++;
          fall_prev = cyc;
        end
        we_run++;
      end else if (!p_we) begin
        if (we_run != WP) tim_err++;
        we_run = 0;
        ld_addr[nloads % 64] = mem_addr;
        ld_data[nloads % 64] = mem_dq_o;
        mem_arr[mem_addr] = mem_dq_o;
        last_byte = mem_dq_o;
        nloads++;
        busy_cnt = busy_len;
        last_rise = cyc;
        hd_pend = 1;
        hd_run = 1;
      end else if (hd_pend) begin
        if (mem_dq_oe && !mem_ce_n && mem_addr == p_addr && mem_dq_o == p_dq) hd_run++;
        else begin
          if (hd_run < HD) tim_err++;
          hd_pend = 0;
        end
      end
      if (mem_we_n && mem_dq_oe && !mem_ce_n)
        su_run = (mem_addr == p_addr && mem_dq_o == p_dq && su_run > 0) ? su_run + 1 : 1;
      else su_run = 0;
      if (mem_ce_n) fall_prev = -1;
      rdy_in = (busy_cnt == 0);
      if (!mem_oe_n && !mem_ce_n)
        d7_in = (busy_cnt > 0) ? ~last_byte[7] : mem_arr[mem_addr][7];
      else d7_in = 1'b1;
    end
    p_we = mem_we_n;
    p_addr = mem_addr;
    p_dq = mem_dq_o;
  end

  // ---------------- bench helpers ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // 0 = done, 1 = timeout, 2 = rejected
  function automatic int exp_kind(input int addr, input int len, input int busy);
    if (len == 0 || (addr % 32) + len > 32) return 2;
    if (busy > TO) return 1;
    return 0;
  endfunction

  task automatic run_req(input int addr, input int len, input bit poll,
                         input int busy, input int force_last, input string tag);
    logic [7:0] bytes [32];
    int kind_exp, kind, base, t_base, i_base, c_base, n, i_ok;
    bit rd;
    longint d_cyc;
    kind_exp = exp_kind(addr, len, busy);
    base = nloads; t_base = tim_err; i_base = intv_err; c_base = cont_err;
    busy_len = busy;
    for (int i = 0; i < 32; i++) bytes[i] = 8'($urandom);
    if (force_last >= 0 && len > 0) bytes[len-1] = 8'(force_last);
    chk(wd_ready == 1'b0, "R1", {tag, " byte ready while idle"}, wd_ready, 0);
    req_addr = 13'(addr); req_len = 6'(len); req_poll = poll; req_valid = 1'b1;
    n = 0;
    do begin rd = req_ready; tick(); n++; end while (!rd && n < 100);
    req_valid = 1'b0;
    if (kind_exp != 2) begin
      chk(req_ready == 1'b0, "R1", {tag, " request ready while busy"}, req_ready, 0);
      for (int i = 0; i < len; i++) begin
        int gap;
        gap = $urandom_range(0, 2);
        for (int g = 0; g < gap; g++) tick();
        wd_valid = 1'b1; wd_data = bytes[i];
        n = 0;
        do begin rd = wd_ready; tick(); n++; end while (!rd && n < 100);
        wd_valid = 1'b0;
      end
    end
    n = 0;
    while (!(done_o || timeout_o || error_o) && n < 20000) begin tick(); n++; end
    d_cyc = cyc;
    kind = done_o ? 0 : timeout_o ? 1 : error_o ? 2 : 3;
    chk(kind == kind_exp, "R10", {tag, " result kind"}, kind, kind_exp);
    if (kind_exp == 2) begin
      chk(nloads == base, "R2", {tag, " loads after reject"}, nloads - base, 0);
      tick();
      chk(wd_ready == 1'b0 && req_ready == 1'b1, "R2", {tag, " no bytes taken"}, wd_ready, 0);
    end else begin
      chk(nloads - base == len, "R3", {tag, " load count"}, nloads - base, len);
      i_ok = 1;
      for (int i = 0; i < len; i++) begin
        int ea;
        ea = (addr & 13'h1FE0) | ((addr + i) & 31);
        if (ld_addr[(base + i) % 64] != 13'(ea) || ld_data[(base + i) % 64] != bytes[i]) begin
          i_ok = 0;
          chk(0, "R3", {tag, " load address"}, ld_addr[(base + i) % 64], ea);
        end
      end
      chk(i_ok == 1, "R3", {tag, " all loads in order"}, i_ok, 1);
      chk(tim_err == t_base, "R4", {tag, " strobe timing faults"}, tim_err - t_base, 0);
      chk(intv_err == i_base, "R5", {tag, " load spacing faults"}, intv_err - i_base, 0);
      chk(cont_err == c_base, "R7", {tag, " bus fights"}, cont_err - c_base, 0);
      if (kind == 0) begin
        chk(d_cyc > busy_end && d_cyc - busy_end <= OE + GP + ST + 4,
            poll ? "R6" : "R8", {tag, " done vs busy end"}, d_cyc - busy_end, 1);
      end
      if (kind == 1) begin
        chk(d_cyc - last_rise >= TO && d_cyc - last_rise <= TO + HD + OE + GP + ST + 6,
            "R9", {tag, " timeout latency"}, d_cyc - last_rise, TO);
        while (busy_cnt > 0) tick();
      end
    end
    n = 0;
    for (int k = 0; k < 4; k++) begin
      tick();
      if (done_o || timeout_o || error_o) n++;
    end
    chk(n == 0, "R10", {tag, " extra result pulse"}, n, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'd20240611);
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R11", "strobes after reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, "R11", "bus released after reset", mem_dq_oe, 0);
    chk(req_ready && !wd_ready, "R11", "ready flags after reset", {req_ready, wd_ready}, 2);
    chk(!done_o && !timeout_o && !error_o, "R11", "pulses after reset",
        {done_o, timeout_o, error_o}, 0);

    run_req(13'h0040, 0,  1, 100, -1, "zero length");
    run_req(13'h005E, 3,  1, 100, -1, "crosses page");
    run_req(13'h0081, 32, 0, 100, -1, "one past page");
    run_req(13'h0100, 32, 1, 250, -1, "full page poll");
    run_req(13'h1FFF, 1,  0, 60,  8'h00, "last offset ready");
    run_req(13'h003F, 1,  1, 80,  8'h7F, "last offset poll bit7 low");
    run_req(13'h0A1F, 1,  1, 80,  8'hFF, "last offset poll bit7 high");
    run_req(13'h0205, 8,  1, TO + 200, 8'h80, "poll timeout");
    run_req(13'h0305, 4,  0, TO + 200, -1, "ready timeout");

    for (int r = 0; r < 14; r++) begin
      int off, len, pg;
      pg  = $urandom_range(0, 255);
      off = $urandom_range(0, 31);
      len = $urandom_range(1, 32 - off);
      run_req((pg << 5) | off, len, 1'($urandom), $urandom_range(20, 300), -1, "random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule